// File: doc/BRIEF.md
# Scaled Fixed-Point System Counter

This block keeps a chip-wide timestamp. Inside it sits an 88-bit accumulator in fixed-point form, with 64 integer bits and 24 fraction bits. Only the integer part is visible, as a 64-bit count that goes straight to downstream timers on `count_o`. Each cycle in which the reference tick input is high, the accumulator grows by one of two amounts. With scaling switched off it grows by exactly one whole unit. With scaling switched on it grows by a programmable 32-bit increment, which lets the count run at a rational multiple of the tick rate.

Software reaches the block through two separate register windows of 4 KB each. Each window has its own APB-style select, enable and one-cycle ready. The control window holds the control bits, the scale value, an identification word and a writable copy of the count, which is written one 32-bit half at a time. The status window is read-only. It gives the two count words and the same block of identification bytes, except that the first peripheral byte differs.

Top module: `sysctr_top`

## Requirements
- R1: After reset the control word reads 0, the scale register reads 0x01000000, and both count words and `count_o` are 0.
- R2: When control bit 0 (run) is 1 and control bit 2 (scale enable) is 0, every cycle with `tick_i` high raises `count_o` by exactly 1. The scale value has no influence in this mode.
- R3: When run and scale enable are both 1, every tick adds the 32-bit scale value to the 88-bit accumulator. `count_o` is that accumulator shifted right by 24, so after N ticks from a cleared accumulator the count equals floor(N*scale/2^24).
- R4: While run is 0, ticks are ignored and `count_o` holds its value.
- R5: A control-window write to offset 0x08 replaces count bits 31:0, and a write to offset 0x0C replaces bits 63:32. The other half keeps its running value, and the 24 fraction bits are cleared. If a tick falls in the same cycle, the write wins and the tick is dropped. The count wraps from all ones to zero.
- R6: The control word at offset 0x00 stores bits 4:0: run (bit 0), halt-on-debug (bit 1), scale enable (bit 2), interrupt mask (bit 3) and error-response disable (bit 4). Bits 31:5 read as zero and ignore writes.
- R7: In the control window, offset 0x04 reads zero. Offsets 0x10 and 0xD0 are the same scale register. Offset 0xD4 reads zero and ignores writes. Offset 0x1C reads 0x00020001, where bit 0 flags that scaling is present. Any unmapped or non-word-aligned offset reads zero, and writes to it change nothing.
- R8: The status window returns count bits 31:0 at offset 0x00 and bits 63:32 at offset 0x04. Status accesses with `sts_pwrite` high change no state and return zero data.
- R9: Both windows return identification bytes in the low 8 bits of words 0xFD0 to 0xFFC: 0xFD0=0x04, 0xFE0=0xBA (control) or 0xBB (status), 0xFE4=0xB0, 0xFE8=0x0B, 0xFF0=0x0D, 0xFF4=0xF0, 0xFF8=0x05, 0xFFC=0xB1. All other words in that range read zero.
- R10: Each window raises its ready output during every access phase, so each access ends in one cycle, whatever its offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Reference tick, one increment per high cycle |
| ctl_psel | input | 1 | Control window select |
| ctl_penable | input | 1 | Control window access phase |
| ctl_pwrite | input | 1 | Control window write strobe |
| ctl_paddr | input | 12 | Control window byte offset |
| ctl_pwdata | input | 32 | Control window write data |
| ctl_prdata | output | 32 | Control window read data |
| ctl_pready | output | 1 | Control window ready |
| sts_psel | input | 1 | Status window select |
| sts_penable | input | 1 | Status window access phase |
| sts_pwrite | input | 1 | Status window write strobe (ignored) |
| sts_paddr | input | 12 | Status window byte offset |
| sts_prdata | output | 32 | Status window read data |
| sts_pready | output | 1 | Status window ready |
| count_o | output | 64 | Integer part of the accumulator |

## Verification
Read data is combinational on the current register state during the access phase. It is therefore sampled shortly after the falling edge that opens the access phase, when everything from earlier rising edges has settled. A write, or a change of the run and scale bits, takes effect at the rising edge that ends its access phase, so the first read that can observe it is the next transaction. The bench holds `tick_i` high for exactly N rising edges, and the count is due N increments later, one cycle after the last of them. Tick and bus activity are kept apart except in the test that places them in the same cycle on purpose.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;

   // Control window word offsets (byte addresses)
   localparam logic [11:0] OFS_CTRL   = 12'h000;
   localparam logic [11:0] OFS_STAT   = 12'h004;
   localparam logic [11:0] OFS_CNTLO  = 12'h008;
   localparam logic [11:0] OFS_CNTHI  = 12'h00C;
   localparam logic [11:0] OFS_SCALE  = 12'h010;
   localparam logic [11:0] OFS_IDENT  = 12'h01C;
   localparam logic [11:0] OFS_SCALEA = 12'h0D0;
   localparam logic [11:0] OFS_SCALE1 = 12'h0D4;

   // Status window offsets
   localparam logic [11:0] OFS_SLO    = 12'h000;
   localparam logic [11:0] OFS_SHI    = 12'h004;

   // Identification byte block
   localparam logic [11:0] OFS_IDB_LO = 12'hFD0;
   localparam logic [11:0] OFS_IDB_HI = 12'hFFC;
   localparam logic [3:0]  IDB_BIAS   = 4'h4;   // word index bits [5:2] at 0xFD0

   localparam logic [7:0]  PID0_CTL   = 8'hBA;
   localparam logic [7:0]  PID0_STS   = 8'hBB;

   typedef struct packed {
      logic errdis;
      logic imask;
      logic scen;
      logic hdbg;
      logic run;
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);

   function automatic logic [7:0] idb_value(input logic [3:0] idx,
                                            input logic [7:0] pid0);
      logic [7:0] v;
      case (idx)
         4'd0:    v = 8'h04;
         4'd4:    v = pid0;
         4'd5:    v = 8'hB0;
         4'd6:    v = 8'h0B;
         4'd8:    v = 8'h0D;
         4'd9:    v = 8'hF0;
         4'd10:   v = 8'h05;
         4'd11:   v = 8'hB1;
         default: v = 8'h00;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/sysctr_idrom.sv
module sysctr_idrom
   import sysctr_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter logic [7:0] PID0 = 8'hBA
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [DATA_W-1:0] data
);

   logic [3:0] idx;

   always_comb begin
      hit  = (addr >= ADDR_W'(OFS_IDB_LO)) && (addr <= ADDR_W'(OFS_IDB_HI))
             && (addr[1:0] == 2'b00);
      idx  = addr[5:2] - IDB_BIAS;
      data = hit ? DATA_W'(idb_value(idx, PID0)) : '0;
   end

endmodule

// File: rtl/sysctr_accum.sv
module sysctr_accum #(
   parameter int CNT_W   = 64,
   parameter int FRAC_W  = 24,
   parameter int DATA_W  = 32,
   parameter int SCALE_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step,
   input  logic [SCALE_W-1:0] inc,
   input  logic               ld_lo,
   input  logic               ld_hi,
   input  logic [DATA_W-1:0]  ld_data,
   output logic [CNT_W-1:0]   count
);

   localparam int ACC_W = CNT_W + FRAC_W;
   localparam int LO_TOP = FRAC_W + DATA_W - 1;

   logic [ACC_W-1:0] acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (ld_lo || ld_hi) begin
         acc_q[FRAC_W-1:0] <= '0;
         if (ld_lo) acc_q[LO_TOP:FRAC_W] <= ld_data;
         if (ld_hi) acc_q[ACC_W-1:LO_TOP+1] <= ld_data;
      end else if (step) begin
         acc_q <= acc_q + ACC_W'(inc);
      end
   end

   assign count = acc_q[ACC_W-1:FRAC_W];

endmodule

// File: rtl/sysctr_ctlregs.sv
module sysctr_ctlregs
   import sysctr_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 64,
   parameter int SCALE_W   = 32,
   parameter int FRAC_W    = 24,
   parameter bit HAS_SCALE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               psel,
   input  logic               penable,
   input  logic               pwrite,
   input  logic [ADDR_W-1:0]  paddr,
   input  logic [DATA_W-1:0]  pwdata,
   input  logic [CNT_W-1:0]   count,
   output logic [DATA_W-1:0]  prdata,
   output logic               pready,
   output ctl_t               ctl,
   output logic [SCALE_W-1:0] scale,
   output logic               ld_lo,
   output logic               ld_hi
);

   localparam logic [SCALE_W-1:0] UNIT = SCALE_W'(1) << FRAC_W;
   localparam logic [DATA_W-1:0] IDENT_WORD =
      (DATA_W'(1) << 17) | DATA_W'(HAS_SCALE);

   logic access, wr;
   logic sel_ctrl, sel_lo, sel_hi, sel_scale, sel_ident;
   logic idb_hit;
   logic [DATA_W-1:0] idb_data;
   logic [DATA_W-1:0] rmux;

   ctl_t ctl_q;

   always_comb begin
      access    = psel && penable;
      wr        = access && pwrite;
      sel_ctrl  = (paddr == ADDR_W'(OFS_CTRL));
      sel_lo    = (paddr == ADDR_W'(OFS_CNTLO));
      sel_hi    = (paddr == ADDR_W'(OFS_CNTHI));
      sel_scale = (paddr == ADDR_W'(OFS_SCALE)) || (paddr == ADDR_W'(OFS_SCALEA));
      sel_ident = (paddr == ADDR_W'(OFS_IDENT));
   end

   assign ld_lo  = wr && sel_lo;
   assign ld_hi  = wr && sel_hi;
   assign pready = psel;
   assign ctl    = ctl_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctl_q <= '0;
      else if (wr && sel_ctrl)
         ctl_q <= ctl_t'(pwdata[CTL_W-1:0]);
   end

   generate
      if (HAS_SCALE) begin : g_scale
         logic [SCALE_W-1:0] scale_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               scale_q <= UNIT;
            else if (wr && sel_scale)
               scale_q <= pwdata[SCALE_W-1:0];
         end
         assign scale = scale_q;
      end else begin : g_noscale
         assign scale = UNIT;
      end
   endgenerate

   sysctr_idrom #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .PID0   (PID0_CTL)
   ) u_idb (
      .addr (paddr),
      .hit  (idb_hit),
      .data (idb_data)
   );

   always_comb begin
      rmux = '0;
      if (sel_ctrl)
         rmux = DATA_W'(ctl_q);
      else if (sel_lo)
         rmux = count[DATA_W-1:0];
      else if (sel_hi)
         rmux = count[CNT_W-1:DATA_W];
      else if (sel_scale)
         rmux = HAS_SCALE ? DATA_W'(scale) : '0;
      else if (sel_ident)
         rmux = IDENT_WORD;
      else if (idb_hit)
         rmux = idb_data;
      prdata = (access && !pwrite) ? rmux : '0;
   end

endmodule

// File: rtl/sysctr_stsregs.sv
module sysctr_stsregs
   import sysctr_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 64
) (
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [CNT_W-1:0]  count,
   output logic [DATA_W-1:0] prdata,
   output logic              pready
);

   logic idb_hit;
   logic [DATA_W-1:0] idb_data;
   logic [DATA_W-1:0] rmux;

   sysctr_idrom #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .PID0   (PID0_STS)
   ) u_idb (
      .addr (paddr),
      .hit  (idb_hit),
      .data (idb_data)
   );

   always_comb begin
      if (paddr == ADDR_W'(OFS_SLO))
         rmux = count[DATA_W-1:0];
      else if (paddr == ADDR_W'(OFS_SHI))
         rmux = count[CNT_W-1:DATA_W];
      else
         rmux = idb_data;
      prdata = (psel && penable && !pwrite) ? rmux : '0;
   end

   assign pready = psel;

endmodule

// File: rtl/sysctr_top.sv
module sysctr_top
   import sysctr_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 64,
   parameter int FRAC_W    = 24,
   parameter int SCALE_W   = 32,
   parameter bit HAS_SCALE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              ctl_psel,
   input  logic              ctl_penable,
   input  logic              ctl_pwrite,
   input  logic [ADDR_W-1:0] ctl_paddr,
   input  logic [DATA_W-1:0] ctl_pwdata,
   output logic [DATA_W-1:0] ctl_prdata,
   output logic              ctl_pready,
   input  logic              sts_psel,
   input  logic              sts_penable,
   input  logic              sts_pwrite,
   input  logic [ADDR_W-1:0] sts_paddr,
   output logic [DATA_W-1:0] sts_prdata,
   output logic              sts_pready,
   output logic [CNT_W-1:0]  count_o
);

   localparam logic [SCALE_W-1:0] UNIT = SCALE_W'(1) << FRAC_W;

   initial begin : p_param_check
      assert (CNT_W == 2 * DATA_W)
         else $fatal(1, "count width must be two data words");
      assert (FRAC_W < SCALE_W && SCALE_W <= DATA_W)
         else $fatal(1, "scale must hold one unit and fit a data word");
      assert (ADDR_W >= 12)
         else $fatal(1, "window needs at least 12 offset bits");
   end

   ctl_t               ctl;
   logic [SCALE_W-1:0] scale;
   logic [SCALE_W-1:0] inc;
   logic               ld_lo, ld_hi;
   logic [CNT_W-1:0]   count;

   sysctr_ctlregs #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .CNT_W     (CNT_W),
      .SCALE_W   (SCALE_W),
      .FRAC_W    (FRAC_W),
      .HAS_SCALE (HAS_SCALE)
   ) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .psel    (ctl_psel),
      .penable (ctl_penable),
      .pwrite  (ctl_pwrite),
      .paddr   (ctl_paddr),
      .pwdata  (ctl_pwdata),
      .count   (count),
      .prdata  (ctl_prdata),
      .pready  (ctl_pready),
      .ctl     (ctl),
      .scale   (scale),
      .ld_lo   (ld_lo),
      .ld_hi   (ld_hi)
   );

   generate
      if (HAS_SCALE) begin : g_inc_scaled
         assign inc = ctl.scen ? scale : UNIT;
      end else begin : g_inc_unit
         assign inc = UNIT;
      end
   endgenerate

   sysctr_accum #(
      .CNT_W   (CNT_W),
      .FRAC_W  (FRAC_W),
      .DATA_W  (DATA_W),
      .SCALE_W (SCALE_W)
   ) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (ctl.run && tick_i),
      .inc     (inc),
      .ld_lo   (ld_lo),
      .ld_hi   (ld_hi),
      .ld_data (ctl_pwdata),
      .count   (count)
   );

   sysctr_stsregs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_sts (
      .psel    (sts_psel),
      .penable (sts_penable),
      .pwrite  (sts_pwrite),
      .paddr   (sts_paddr),
      .count   (count),
      .prdata  (sts_prdata),
      .pready  (sts_pready)
   );

   assign count_o = count;

endmodule

// File: rtl/sysctr_chk.sv
module sysctr_chk
   import sysctr_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic              ctl_psel,
   input logic              ctl_penable,
   input logic              ctl_pwrite,
   input logic [ADDR_W-1:0] ctl_paddr,
   input logic [DATA_W-1:0] ctl_pwdata,
   input logic              ctl_pready,
   input logic              sts_psel,
   input logic              sts_penable,
   input logic              sts_pwrite,
   input logic [ADDR_W-1:0] sts_paddr,
   input logic [DATA_W-1:0] sts_prdata,
   input logic              sts_pready,
   input logic              run,
   input logic              scen,
   input logic [CNT_W-1:0]  count_o
);

   logic cwr, cwr_lo, cwr_hi;
   assign cwr    = ctl_psel && ctl_penable && ctl_pwrite;
   assign cwr_lo = cwr && (ctl_paddr == ADDR_W'(OFS_CNTLO));
   assign cwr_hi = cwr && (ctl_paddr == ADDR_W'(OFS_CNTHI));

   AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cwr_lo && !cwr_hi) |=> $stable(count_o)); // R4

   AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !scen && tick_i && !cwr_lo && !cwr_hi)
      |=> (count_o == $past(count_o) + CNT_W'(1))); // R2

   AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cwr_lo |=> (count_o[DATA_W-1:0] == $past(ctl_pwdata))); // R5

   AST_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cwr_hi |=> (count_o[CNT_W-1:DATA_W] == $past(ctl_pwdata))
                 && (count_o[DATA_W-1:0] == $past(count_o[DATA_W-1:0]))); // R5

   AST_STS_LOWORD: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_psel && sts_penable && !sts_pwrite && sts_paddr == ADDR_W'(OFS_SLO))
      |-> (sts_prdata == count_o[DATA_W-1:0])); // R8

   AST_READY_CTL: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_psel && ctl_penable) |-> ctl_pready); // R10

   AST_READY_STS: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_psel && sts_penable) |-> sts_pready); // R10

endmodule

bind sysctr_top sysctr_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_i      (tick_i),
   .ctl_psel    (ctl_psel),
   .ctl_penable (ctl_penable),
   .ctl_pwrite  (ctl_pwrite),
   .ctl_paddr   (ctl_paddr),
   .ctl_pwdata  (ctl_pwdata),
   .ctl_pready  (ctl_pready),
   .sts_psel    (sts_psel),
   .sts_penable (sts_penable),
   .sts_pwrite  (sts_pwrite),
   .sts_paddr   (sts_paddr),
   .sts_prdata  (sts_prdata),
   .sts_pready  (sts_pready),
   .run         (ctl.run),
   .scen        (ctl.scen),
   .count_o     (count_o)
);

// File: tb/sysctr_top_test.sv
module sysctr_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        ctl_psel = 1'b0, ctl_penable = 1'b0, ctl_pwrite = 1'b0;
   logic [11:0] ctl_paddr = '0;
   logic [31:0] ctl_pwdata = '0;
   logic [31:0] ctl_prdata;
   logic        ctl_pready;
   logic        sts_psel = 1'b0, sts_penable = 1'b0, sts_pwrite = 1'b0;
   logic [11:0] sts_paddr = '0;
   logic [31:0] sts_prdata;
   logic        sts_pready;
   logic [63:0] count_o;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   sysctr_top uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .ctl_psel(ctl_psel), .ctl_penable(ctl_penable), .ctl_pwrite(ctl_pwrite),
      .ctl_paddr(ctl_paddr), .ctl_pwdata(ctl_pwdata), .ctl_prdata(ctl_prdata),
      .ctl_pready(ctl_pready),
      .sts_psel(sts_psel), .sts_penable(sts_penable), .sts_pwrite(sts_pwrite),
      .sts_paddr(sts_paddr), .sts_prdata(sts_prdata), .sts_pready(sts_pready),
      .count_o(count_o)
   );

   // {scale, ticks, expected count}
   localparam logic [95:0] VEC [6] = '{
      {32'h0100_0000, 32'd10, 32'd10},
      {32'h0080_0000, 32'd7,  32'd3},
      {32'h0200_0000, 32'd5,  32'd10},
      {32'h0055_5555, 32'd9,  32'd2},
      {32'hFFFF_FFFF, 32'd3,  32'h2FF},
      {32'h0000_0000, 32'd4,  32'd0}
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic ctl_wr(input logic [11:0] a, input logic [31:0] d, input logic tk = 1'b0);
      @(negedge clk);
      ctl_psel = 1'b1; ctl_pwrite = 1'b1; ctl_paddr = a; ctl_pwdata = d; ctl_penable = 1'b0;
      @(negedge clk);
      ctl_penable = 1'b1; tick_i = tk;
      @(negedge clk);
      ctl_psel = 1'b0; ctl_penable = 1'b0; ctl_pwrite = 1'b0; tick_i = 1'b0;
   endtask

   task automatic ctl_rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      ctl_psel = 1'b1; ctl_pwrite = 1'b0; ctl_paddr = a; ctl_penable = 1'b0;
      @(negedge clk);
      ctl_penable = 1'b1;
      #1;
      d = ctl_prdata;
      check("R10 ctl ready", {63'd0, ctl_pready}, 64'd1);
      @(negedge clk);
      ctl_psel = 1'b0; ctl_penable = 1'b0;
   endtask

   task automatic sts_acc(input logic [11:0] a, input logic w, output logic [31:0] d);
      @(negedge clk);
      sts_psel = 1'b1; sts_pwrite = w; sts_paddr = a; sts_penable = 1'b0;
      @(negedge clk);
      sts_penable = 1'b1;
      #1;
      d = sts_prdata;
      check("R10 sts ready", {63'd0, sts_pready}, 64'd1);
      @(negedge clk);
      sts_psel = 1'b0; sts_penable = 1'b0; sts_pwrite = 1'b0;
   endtask

   task automatic rd_count(output logic [63:0] c);
      logic [31:0] lo, hi;
      ctl_rd(12'h008, lo);
      ctl_rd(12'h00C, hi);
      c = {hi, lo};
   endtask

   task automatic run_ticks(input int n);
      @(negedge clk);
      tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
   endtask

   task automatic clear_count();
      ctl_wr(12'h008, 32'h0);
      ctl_wr(12'h00C, 32'h0);
   endtask

   initial begin : watchdog
      #(8 * 150000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [31:0] r, r2;
      logic [63:0] c;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 count_o", count_o, 64'd0);
      ctl_rd(12'h000, r); check("R1 ctrl", {32'd0, r}, 64'd0);
      ctl_rd(12'h010, r); check("R1 scale", {32'd0, r}, 64'h0100_0000);
      rd_count(c);        check("R1 count words", c, 64'd0);

      // R3 scaled table
      for (int i = 0; i < 6; i++) begin
         ctl_wr(12'h000, 32'h0);
         clear_count();
         ctl_wr(12'h010, VEC[i][95:64]);
         ctl_wr(12'h000, 32'h5);
         run_ticks(int'(VEC[i][63:32]));
         ctl_wr(12'h000, 32'h0);
         rd_count(c);
         check($sformatf("R3 vector %0d", i), c, {32'd0, VEC[i][31:0]});
      end

      // R2 unit stepping ignores the scale value
      clear_count();
      ctl_wr(12'h010, 32'h0000_0003);
      ctl_wr(12'h000, 32'h1);
      run_ticks(20);
      ctl_wr(12'h000, 32'h0);
      rd_count(c);
      check("R2 unit count", c, 64'd20);
      check("R2 count_o port", count_o, 64'd20);

      // R4 stopped counter ignores ticks
      run_ticks(15);
      rd_count(c);
      check("R4 hold", c, 64'd20);

      // R5 high-half write keeps the low half
      ctl_wr(12'h00C, 32'hABCD_0001);
      rd_count(c);
      check("R5 hi write", c, 64'hABCD_0001_0000_0014);

      // R5 fraction cleared by a half write
      clear_count();
      ctl_wr(12'h010, 32'h0080_0000);
      ctl_wr(12'h000, 32'h5);
      run_ticks(1);
      ctl_wr(12'h008, 32'd5);
      run_ticks(1);
      ctl_wr(12'h000, 32'h0);
      rd_count(c);
      check("R5 fraction cleared", c, 64'd5);

      // R5 write wins over a tick in the same cycle
      clear_count();
      ctl_wr(12'h000, 32'h1);
      ctl_wr(12'h008, 32'd100, 1'b1);
      ctl_wr(12'h000, 32'h0);
      rd_count(c);
      check("R5 write beats tick", c, 64'd100);

      // R5 wrap from all ones
      ctl_wr(12'h008, 32'hFFFF_FFFF);
      ctl_wr(12'h00C, 32'hFFFF_FFFF);
      ctl_wr(12'h000, 32'h1);
      run_ticks(1);
      ctl_wr(12'h000, 32'h0);
      rd_count(c);
      check("R5 wrap", c, 64'd0);

      // R6 control mask
      ctl_wr(12'h000, 32'hFFFF_FFFF);
      ctl_rd(12'h000, r);
      check("R6 ctrl mask", {32'd0, r}, 64'h1F);
      ctl_wr(12'h000, 32'h0);
      ctl_rd(12'h000, r);
      check("R6 ctrl cleared", {32'd0, r}, 64'h0);

      // R7 map details
      ctl_rd(12'h004, r); check("R7 status word", {32'd0, r}, 64'd0);
      ctl_rd(12'h01C, r); check("R7 ident word", {32'd0, r}, 64'h0002_0001);
      ctl_wr(12'h0D0, 32'h1234_5678);
      ctl_rd(12'h010, r); check("R7 scale alias", {32'd0, r}, 64'h1234_5678);
      ctl_wr(12'h0D4, 32'h0000_0055);
      ctl_rd(12'h0D4, r); check("R7 second scale reads zero", {32'd0, r}, 64'd0);
      ctl_rd(12'h0D0, r); check("R7 scale after 0xD4 write", {32'd0, r}, 64'h1234_5678);
      ctl_wr(12'h040, 32'hFFFF_FFFF);
      ctl_wr(12'h004, 32'hFFFF_FFFF);
      ctl_wr(12'h011, 32'hFFFF_FFFF);
      ctl_rd(12'h000, r); check("R7 ctrl after bad writes", {32'd0, r}, 64'd0);
      ctl_rd(12'h010, r); check("R7 scale after bad writes", {32'd0, r}, 64'h1234_5678);
      ctl_rd(12'h040, r); check("R7 unmapped read", {32'd0, r}, 64'd0);
      ctl_rd(12'h011, r); check("R7 unaligned read", {32'd0, r}, 64'd0);

      // R8 status window
      ctl_wr(12'h008, 32'hCAFE_0042);
      ctl_wr(12'h00C, 32'h0000_7777);
      sts_acc(12'h000, 1'b0, r);  check("R8 status low", {32'd0, r}, 64'hCAFE_0042);
      sts_acc(12'h004, 1'b0, r2); check("R8 status high", {32'd0, r2}, 64'h7777);
      sts_acc(12'h000, 1'b1, r);  check("R8 status write data zero", {32'd0, r}, 64'd0);
      sts_acc(12'h004, 1'b1, r);
      rd_count(c);
      check("R8 count after status writes", c, 64'h0000_7777_CAFE_0042);

      // R9 identification bytes
      ctl_rd(12'hFE0, r);        check("R9 ctl pid0", {32'd0, r}, 64'hBA);
      sts_acc(12'hFE0, 1'b0, r); check("R9 sts pid0", {32'd0, r}, 64'hBB);
      ctl_rd(12'hFD0, r);        check("R9 pid4", {32'd0, r}, 64'h04);
      sts_acc(12'hFE8, 1'b0, r); check("R9 pid2", {32'd0, r}, 64'h0B);
      ctl_rd(12'hFF4, r);        check("R9 cid1", {32'd0, r}, 64'hF0);
      sts_acc(12'hFFC, 1'b0, r); check("R9 cid3", {32'd0, r}, 64'hB1);
      sts_acc(12'hFDC, 1'b0, r); check("R9 pid7", {32'd0, r}, 64'h00);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule